// File: doc/BRIEF.md
# Single-Wire Bus Master Interrupt and Status Registers

This block holds the interrupt side of a single-wire bus master as a host sees it through a byte-wide register port. The bus engine, which is outside this block, reports four kinds of event as one-cycle pulses. The first is the end of a reset/presence cycle, which comes with a flag telling whether any slave answered. The other three are the transmit shift register emptying, a received byte landing in the receive buffer, and the receive shift register filling. The block latches each event into a status flag, stores the received byte, and drives one interrupt line. That line is raised whenever a latched flag has its enable bit set.

The host clears status by reading it. A read of the status register returns the flags and clears the event flags in that same cycle. The receive-full flag is the exception: it is cleared only by reading the received byte. One enable bit picks the active level of the interrupt line, and another enable bit is passed out to the bus engine as its direct-drive permission. Register reads are registered, so read data appears on the port one cycle after the read strobe.

Top module: `ow_irq_ctrl`

## Requirements
- R1: After reset the status, enable and receive data registers read 0x00, the interrupt line is high (inactive for the reset polarity), and the direct-drive output is low.
- R2: Offset 0x02 reads the status register. Bit 0 (presence cycle done), bit 2 (transmit empty) and bit 5 (receive shift register full) are set by their event pulses and cleared by a status read.
- R3: Status bit 1 holds the presence result: it is loaded with 1 when the presence-done pulse reports that no slave answered, or with 0 when one did. A status read does not clear it.
- R4: A receive-full pulse loads the received byte into the data register (offset 0x01) and sets status bit 4. A data read returns the byte and clears bit 4; a status read leaves bit 4 set.
- R5: The interrupt request is asserted one clock after a status flag at bit 0, 2, 4 or 5 and its enable bit at the same position are both set.
- R6: Enable bit 7 picks the polarity: 1 gives an active-high interrupt line, 0 gives an active-low one.
- R7: When enable bits 0, 2, 4 and 5 are all zero, the interrupt line stays at its inactive level whatever the flags and whatever the polarity bit.
- R8: A status read that clears the only active source drops the interrupt line one clock after the read edge.
- R9: An event pulse that arrives in the same cycle as a read that would clear its flag leaves the flag set.
- R10: Offset 0x03 reads back the enable register as written, and enable bit 6 drives the direct-drive output. Reads of any other offset return 0x00, and writes to offsets other than 0x03 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 3 | Register offset |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after the strobe |
| ev_presence_done | input | 1 | Reset/presence cycle finished |
| ev_presence_absent | input | 1 | Qualifies ev_presence_done: no slave answered |
| ev_tx_empty | input | 1 | Transmit shift register emptied |
| ev_rx_full | input | 1 | Received byte available on rx_byte |
| rx_byte | input | 8 | Received byte |
| ev_rxsr_full | input | 1 | Receive shift register filled |
| direct_drive_en | output | 1 | Direct bus drive permission (enable bit 6) |
| irq_line | output | 1 | Interrupt output, polarity set by enable bit 7 |

## Verification
An event pulse sampled at clock edge k sets its flag at k. The interrupt line, which is registered from the flags, follows at edge k+1. Read data is captured at the read edge and shows the register contents from before any clear done by that same read. The bench drives every strobe for exactly one edge and moves its reference model forward at that edge. It compares read data at the falling edge after the read edge, and it checks the interrupt line only after one further full clock, so every comparison samples the cycle in which the result is due.

// File: rtl/ow_irq_pkg.sv
package ow_irq_pkg;

  localparam int REG_W  = 8;
  localparam int ADDR_W = 3;

  // register offsets, decoded by the host side
  localparam int OFS_DATA   = 1;
  localparam int OFS_STATUS = 2;
  localparam int OFS_ENABLE = 3;

  // bit positions shared by status and enable
  localparam int POS_PD   = 0;
  localparam int POS_PRES = 1;
  localparam int POS_TXE  = 2;
  localparam int POS_RXF  = 4;
  localparam int POS_RSF  = 5;
  localparam int POS_DIR  = 6;
  localparam int POS_POL  = 7;

  localparam int NUM_FLAGS = 4;

  localparam logic [REG_W-1:0] SRC_MASK =
    REG_W'((1 << POS_PD) | (1 << POS_TXE) | (1 << POS_RXF) | (1 << POS_RSF));

  typedef struct packed {
    logic pd;
    logic absent;
    logic txe;
    logic rxf;
    logic rsf;
  } bus_evt_t;

  // position of sticky flag number idx
  function automatic int flag_pos(input int idx);
    case (idx)
      0:       return POS_PD;
      1:       return POS_TXE;
      2:       return POS_RXF;
      default: return POS_RSF;
    endcase
  endfunction

  // the receive-full flag is owned by the data register read
  function automatic bit cleared_by_data(input int pos);
    return pos == POS_RXF;
  endfunction

  // level of the interrupt pin for given status and enable
  function automatic logic irq_level(input logic [REG_W-1:0] stat,
                                     input logic [REG_W-1:0] en);
    logic req;
    req = |(stat & en & SRC_MASK);
    return ~(req ^ en[POS_POL]);
  endfunction

endpackage

// File: rtl/ow_host_decode.sv
module ow_host_decode
  import ow_irq_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  output logic          rd_data,
  output logic          rd_status,
  output logic          rd_enable,
  output logic          wr_enable
);

  localparam int NUM_OFS = 1 << AW;

  logic [NUM_OFS-1:0] sel;

  for (genvar g = 0; g < NUM_OFS; g++) begin : g_sel
    assign sel[g] = (addr == AW'(g));
  end

  assign rd_data   = rd & sel[OFS_DATA];
  assign rd_status = rd & sel[OFS_STATUS];
  assign rd_enable = rd & sel[OFS_ENABLE];
  assign wr_enable = wr & sel[OFS_ENABLE];

endmodule

// File: rtl/ow_flag_cell.sv
module ow_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);

  // a set in the clearing cycle wins
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

endmodule

// File: rtl/ow_event_flags.sv
module ow_event_flags
  import ow_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  bus_evt_t         evt,
  input  logic             rd_status,
  input  logic             rd_data,
  output logic [REG_W-1:0] status
);

  logic [REG_W-1:0]     evt_vec;
  logic [NUM_FLAGS-1:0] flag_q;
  logic                 absent_q;

  always_comb begin
    evt_vec          = '0;
    evt_vec[POS_PD]  = evt.pd;
    evt_vec[POS_TXE] = evt.txe;
    evt_vec[POS_RXF] = evt.rxf;
    evt_vec[POS_RSF] = evt.rsf;
  end

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    localparam int P = flag_pos(i);
    logic clr_src;
    if (cleared_by_data(P)) begin : g_dclr
      assign clr_src = rd_data;
    end else begin : g_sclr
      assign clr_src = rd_status;
    end
    ow_flag_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (evt_vec[P]),
      .clr   (clr_src),
      .q     (flag_q[i])
    );
  end

  // presence result follows each presence cycle, reads leave it alone
  always_ff @(posedge clk) begin
    if (!rst_n)      absent_q <= 1'b0;
    else if (evt.pd) absent_q <= evt.absent;
  end

  always_comb begin
    status           = '0;
    status[POS_PRES] = absent_q;
    for (int i = 0; i < NUM_FLAGS; i++) status[flag_pos(i)] = flag_q[i];
  end

endmodule

// File: rtl/ow_irq_drive.sv
module ow_irq_drive
  import ow_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_enable,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] status,
  output logic [REG_W-1:0] enable,
  output logic             direct_drive_en,
  output logic             irq_line
);

  always_ff @(posedge clk) begin
    if (!rst_n)         enable <= '0;
    else if (wr_enable) enable <= wdata;
  end

  // registered pin, inactive level for the reset polarity is high
  always_ff @(posedge clk) begin
    if (!rst_n) irq_line <= 1'b1;
    else        irq_line <= irq_level(status, enable);
  end

  assign direct_drive_en = enable[POS_DIR];

endmodule

// File: rtl/ow_rx_hold.sv
module ow_rx_hold
  import ow_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [REG_W-1:0] byte_in,
  output logic [REG_W-1:0] held
);

  always_ff @(posedge clk) begin
    if (!rst_n)    held <= '0;
    else if (load) held <= byte_in;
  end

endmodule

// File: rtl/ow_irq_ctrl.sv
module ow_irq_ctrl
  import ow_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              ev_presence_done,
  input  logic              ev_presence_absent,
  input  logic              ev_tx_empty,
  input  logic              ev_rx_full,
  input  logic [REG_W-1:0]  rx_byte,
  input  logic              ev_rxsr_full,
  output logic              direct_drive_en,
  output logic              irq_line
);

  logic             rd_data_w;
  logic             rd_status_w;
  logic             rd_enable_w;
  logic             wr_enable_w;
  logic [REG_W-1:0] status_w;
  logic [REG_W-1:0] enable_w;
  logic [REG_W-1:0] data_w;
  bus_evt_t         evt_w;

  assign evt_w = '{pd:     ev_presence_done,
                   absent: ev_presence_absent,
                   txe:    ev_tx_empty,
                   rxf:    ev_rx_full,
                   rsf:    ev_rxsr_full};

  ow_host_decode #(.AW(ADDR_W)) u_dec (
    .addr      (reg_addr),
    .rd        (reg_rd),
    .wr        (reg_wr),
    .rd_data   (rd_data_w),
    .rd_status (rd_status_w),
    .rd_enable (rd_enable_w),
    .wr_enable (wr_enable_w)
  );

  ow_event_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (evt_w),
    .rd_status (rd_status_w),
    .rd_data   (rd_data_w),
    .status    (status_w)
  );

  ow_irq_drive u_irq (
    .clk             (clk),
    .rst_n           (rst_n),
    .wr_enable       (wr_enable_w),
    .wdata           (reg_wdata),
    .status          (status_w),
    .enable          (enable_w),
    .direct_drive_en (direct_drive_en),
    .irq_line        (irq_line)
  );

  ow_rx_hold u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ev_rx_full),
    .byte_in (rx_byte),
    .held    (data_w)
  );

  // read data captures contents from before any clear of the same edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      unique case (1'b1)
        rd_data_w:   reg_rdata <= data_w;
        rd_status_w: reg_rdata <= status_w;
        rd_enable_w: reg_rdata <= enable_w;
        default:     reg_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/ow_irq_ctrl_chk.sv
module ow_irq_ctrl_chk
  import ow_irq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             rd_status,
  input logic             rd_data,
  input logic             evt_pd,
  input logic             evt_txe,
  input logic             evt_rxf,
  input logic             evt_rsf,
  input logic [REG_W-1:0] rx_byte,
  input logic [REG_W-1:0] status,
  input logic [REG_W-1:0] enable,
  input logic [REG_W-1:0] data_q,
  input logic             irq_line
);

  AST_PD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pd |=> status[POS_PD]);  // R2

  AST_STATUS_READ_CLEARS_TXE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && !evt_txe) |=> !status[POS_TXE]);  // R2

  AST_RXF_KEPT_BY_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && status[POS_RXF]) |=> status[POS_RXF]);  // R4

  AST_DATA_READ_CLEARS_RXF: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !evt_rxf) |=> !status[POS_RXF]);  // R4

  AST_RX_BYTE_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rxf |=> (data_q == $past(rx_byte)));  // R4

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && evt_rsf) |=> status[POS_RSF]);  // R9

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((enable & SRC_MASK) == '0) |=> (irq_line == !$past(enable[POS_POL])));  // R7

  AST_PD_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (status[POS_PD] && enable[POS_PD] && enable[POS_POL]) |=> irq_line);  // R5

endmodule

bind ow_irq_ctrl ow_irq_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_status (rd_status_w),
  .rd_data   (rd_data_w),
  .evt_pd    (ev_presence_done),
  .evt_txe   (ev_tx_empty),
  .evt_rxf   (ev_rx_full),
  .evt_rsf   (ev_rxsr_full),
  .rx_byte   (rx_byte),
  .status    (status_w),
  .enable    (enable_w),
  .data_q    (data_w),
  .irq_line  (irq_line)
);

// File: tb/ow_irq_ctrl_tb_top.sv
module ow_irq_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_rd = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       ev_pd = 1'b0;
  logic       ev_ab = 1'b0;
  logic       ev_txe = 1'b0;
  logic       ev_rxf = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       ev_rsf = 1'b0;
  logic       direct_drive_en;
  logic       irq_line;

  always #10 clk = ~clk;

  ow_irq_ctrl dut_i (
    .clk                (clk),
    .rst_n              (rst_n),
    .reg_addr           (reg_addr),
    .reg_rd             (reg_rd),
    .reg_wr             (reg_wr),
    .reg_wdata          (reg_wdata),
    .reg_rdata          (reg_rdata),
    .ev_presence_done   (ev_pd),
    .ev_presence_absent (ev_ab),
    .ev_tx_empty        (ev_txe),
    .ev_rx_full         (ev_rxf),
    .rx_byte            (rx_byte),
    .ev_rxsr_full       (ev_rsf),
    .direct_drive_en    (direct_drive_en),
    .irq_line           (irq_line)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model
  logic [7:0] m_stat = '0;
  logic [7:0] m_en   = '0;
  logic [7:0] m_data = '0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         rd_pend = 0;

  task automatic check(input bit ok, input string req, input logic [7:0] act,
                       input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  function automatic logic model_irq();
    logic req = 1'b0;
    int srcs[4] = '{0, 2, 4, 5};
    foreach (srcs[k]) if (m_stat[srcs[k]] && m_en[srcs[k]]) req = 1'b1;
    return m_en[7] ? req : !req;
  endfunction

  // monitor: read results are due the falling edge after the read edge
  always @(posedge clk) rd_pend <= reg_rd;
  always @(negedge clk) begin
    if (rd_pend) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(reg_rdata === e, t, reg_rdata, e);
    end
  end

  // driver: one bus cycle with optional read/write and events
  task automatic cyc(input bit rd, input bit wr, input logic [2:0] a,
                     input logic [7:0] wd, input bit pd, input bit ab,
                     input bit txe, input bit rxf, input logic [7:0] rb,
                     input bit rsf, input string tag);
    @(negedge clk);
    reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    ev_pd = pd; ev_ab = ab; ev_txe = txe; ev_rxf = rxf; rx_byte = rb; ev_rsf = rsf;
    if (rd) begin
      exp_q.push_back(a == 3'd1 ? m_data : a == 3'd2 ? m_stat :
                      a == 3'd3 ? m_en : 8'h00);
      tag_q.push_back(tag);
    end
    @(posedge clk);
    #1;
    if (rd && a == 3'd2) begin m_stat[0] = 0; m_stat[2] = 0; m_stat[5] = 0; end
    if (rd && a == 3'd1) m_stat[4] = 0;
    if (wr && a == 3'd3) m_en = wd;
    if (pd) begin m_stat[0] = 1; m_stat[1] = ab; end
    if (txe) m_stat[2] = 1;
    if (rxf) begin m_stat[4] = 1; m_data = rb; end
    if (rsf) m_stat[5] = 1;
    reg_rd = 0; reg_wr = 0; ev_pd = 0; ev_ab = 0; ev_txe = 0; ev_rxf = 0; ev_rsf = 0;
  endtask

  task automatic rd_reg(input logic [2:0] a, input string tag);
    cyc(1, 0, a, 8'h00, 0, 0, 0, 0, 8'h00, 0, tag);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    cyc(0, 1, a, d, 0, 0, 0, 0, 8'h00, 0, "write");
  endtask

  // the interrupt pin lags the flags by one register
  task automatic check_irq(input string tag);
    @(posedge clk);
    @(negedge clk);
    check(irq_line === model_irq(), tag, {7'd0, irq_line}, {7'd0, model_irq()});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check(irq_line === 1'b1, "R1 irq idle", {7'd0, irq_line}, 8'h01);
    check(direct_drive_en === 1'b0, "R1 direct drive", {7'd0, direct_drive_en}, 8'h00);
    rd_reg(3'd2, "R1 status");
    rd_reg(3'd3, "R1 enable");
    rd_reg(3'd1, "R1 data");

    // R5 R6 active high, presence without slave; R3 result bit
    wr_reg(3'd3, 8'h81);
    check_irq("R6 idle low when active-high");
    cyc(0, 0, 3'd0, 8'h00, 1, 1, 0, 0, 8'h00, 0, "pd");
    check_irq("R5 irq on presence done");
    rd_reg(3'd2, "R2 R3 status 0x03");
    check_irq("R8 irq drops after status read");
    rd_reg(3'd2, "R3 result bit kept 0x02");
    cyc(0, 0, 3'd0, 8'h00, 1, 0, 0, 0, 8'h00, 0, "pd slave");
    rd_reg(3'd2, "R3 result cleared 0x01");

    // R4 R6 receive path, active low
    wr_reg(3'd3, 8'h10);
    cyc(0, 0, 3'd0, 8'h00, 0, 0, 0, 1, 8'hA5, 0, "rx");
    check_irq("R6 active low asserted");
    rd_reg(3'd2, "R4 status keeps rx full 0x10");
    check_irq("R4 irq held after status read");
    rd_reg(3'd1, "R4 data 0xA5");
    rd_reg(3'd2, "R4 rx full cleared by data read");
    check_irq("R4 irq released");

    // R7 masked sources
    wr_reg(3'd3, 8'h80);
    cyc(0, 0, 3'd0, 8'h00, 0, 0, 1, 0, 8'h00, 1, "txe rsf");
    check_irq("R7 masked high polarity");
    wr_reg(3'd3, 8'h00);
    check_irq("R7 masked low polarity");
    rd_reg(3'd2, "R2 status 0x24");
    rd_reg(3'd2, "R2 flags cleared");

    // R9 set wins over clear
    cyc(1, 0, 3'd2, 8'h00, 0, 0, 1, 0, 8'h00, 0, "R9 status during txe");
    rd_reg(3'd2, "R9 txe survived");
    cyc(0, 0, 3'd0, 8'h00, 0, 0, 0, 1, 8'h3C, 0, "rx");
    cyc(1, 0, 3'd1, 8'h00, 0, 0, 0, 1, 8'h5A, 0, "R9 data read during rx");
    rd_reg(3'd2, "R9 rx full survived");
    rd_reg(3'd1, "R9 new byte 0x5A");

    // R5 receive shift full source, active high
    wr_reg(3'd3, 8'hA0);
    cyc(0, 0, 3'd0, 8'h00, 0, 0, 0, 0, 8'h00, 1, "rsf");
    check_irq("R5 rsf raises irq");
    rd_reg(3'd2, "R2 rsf status");
    check_irq("R8 rsf cleared irq");

    // R10 readback, direct drive, unmapped offsets
    wr_reg(3'd3, 8'h40);
    @(negedge clk);
    check(direct_drive_en === 1'b1, "R10 direct drive", {7'd0, direct_drive_en}, 8'h01);
    rd_reg(3'd3, "R10 enable 0x40");
    cyc(0, 0, 3'd0, 8'h00, 0, 0, 1, 0, 8'h00, 0, "txe");
    cyc(0, 1, 3'd2, 8'hFF, 0, 0, 0, 0, 8'h00, 0, "write status");
    cyc(0, 1, 3'd1, 8'hFF, 0, 0, 0, 0, 8'h00, 0, "write data");
    rd_reg(3'd4, "R10 unmapped 0x04");
    rd_reg(3'd0, "R10 unmapped 0x00");
    rd_reg(3'd2, "R10 status unchanged by write");
    rd_reg(3'd1, "R10 data unchanged by write");
    rd_reg(3'd3, "R10 enable unchanged");

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=0x00 expected=0x01");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule